// File: doc/BRIEF.md
# Two-Pipe Operand Bypass Selector

This block sits beside the decode stage of a two-wide in-order pipeline. The two decode slots each carry two source operands, four in total. For every operand it compares the source register number against the destination number and write enable of the four instructions in flight ahead of decode. Those four are the execute and memory stages of pipe 0 and pipe 1. It then picks the newest of the matching producers and hands that value to decode instead of the stale register-file value.

Priority follows program age. A match in execute is newer than any match in memory. Inside one stage, the pipe that holds the younger instruction wins. The pipeline control supplies that pipe as a one-bit input per stage.

A producer in execute that is a load has no data yet. When such a load is the winning producer, the block raises a per-operand stall flag and a combined stall request. The stall sequencer outside the block freezes the early stages and lets the later stages drain.

The block is purely combinational. It has no handshake: every output follows its inputs in the same cycle, and the caller owns all holding and back-pressure through the stall request. Register 7 is the flag register. A compare writes it and a conditional branch reads it, and the decoder presents both as an ordinary destination and an ordinary source with number 7.

Top module: `fwd_unit`

## Requirements
- R1: An operand whose use bit is low, or that matches no enabled producer, gets select code 0 (register file), the register-file value and no stall.
- R2: A producer whose write enable is low is never selected and never causes a stall, even if its destination number matches.
- R3: When an operand matches a producer in execute and another in memory, the execute producer is selected.
- R4: When both pipes of the same stage match, the pipe named by that stage's younger-pipe input is selected (0 = pipe 0, 1 = pipe 1).
- R5: Select codes are 0 register file, 1 execute pipe 0, 2 execute pipe 1, 3 memory pipe 0, 4 memory pipe 1. The data output equals the value of the selected source whenever the operand's stall flag is low.
- R6: When the selected producer is an execute-stage load, the operand's stall flag is high. An older load in execute that is shadowed by a younger non-load match in execute causes no stall.
- R7: A match in the memory stage never causes a stall, since load data is present there.
- R8: Register 7 is forwarded like any other register, so a compare writing number 7 in flight reaches a branch reading number 7.
- R9: Operands are resolved independently in both decode slots, and the stall request is high exactly when at least one operand's stall flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_use | input | 4 | Operand is really read (slot0 op a, slot0 op b, slot1 op a, slot1 op b) |
| src_id | input | 4x3 | Source register number per operand |
| rf_val | input | 4x16 | Register-file value per operand |
| ex_wen | input | 2 | Execute-stage write enable, per pipe |
| ex_dst | input | 2x3 | Execute-stage destination number, per pipe |
| ex_val | input | 2x16 | Execute-stage result, per pipe |
| ex_load | input | 2 | Execute-stage instruction is a load, per pipe |
| ex_young | input | 1 | Pipe holding the younger execute instruction |
| mem_wen | input | 2 | Memory-stage write enable, per pipe |
| mem_dst | input | 2x3 | Memory-stage destination number, per pipe |
| mem_val | input | 2x16 | Memory-stage result or load data, per pipe |
| mem_young | input | 1 | Pipe holding the younger memory instruction |
| op_sel | output | 4x3 | Chosen source code per operand |
| op_val | output | 4x16 | Chosen operand value |
| op_stall | output | 4 | Operand waits on an execute-stage load |
| stall_req | output | 1 | Any operand stalls |

## Verification
Several properties are checked by the assertions on every evaluation of the outputs. A chosen producer must really have its write enable set and a matching destination. The value must follow the select code. A stall must come only from an execute load, and an unused operand must read the register file. The ordering rules can only be shown by the bench's scenarios: execute over memory, younger pipe over older, and a younger non-load hiding an older load. The bench drives both pipes of a stage to match at once, mixes matches across both stages, and produces the load-use stall.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SRC_RF   = 3'd0,
    SRC_EX0  = 3'd1,
    SRC_EX1  = 3'd2,
    SRC_MEM0 = 3'd3,
    SRC_MEM1 = 3'd4
  } src_sel_e;
endpackage

// File: rtl/fwd_stage_pick.sv
// Chooses the newest matching producer among the two pipes of one stage.
module fwd_stage_pick #(
  parameter int REG_W  = 3,
  parameter int DATA_W = 16,
  parameter int PIPES  = 2
) (
  input  logic                          use_i,
  input  logic [REG_W-1:0]              id_i,
  input  logic [PIPES-1:0]              wen_i,
  input  logic [PIPES-1:0][REG_W-1:0]   dst_i,
  input  logic [PIPES-1:0][DATA_W-1:0]  val_i,
  input  logic                          young_i,
  output logic                          hit_o,
  output logic                          pipe_o,
  output logic [DATA_W-1:0]             val_o
);
  logic [PIPES-1:0] match;

  for (genvar p = 0; p < PIPES; p++) begin : g_cmp
    assign match[p] = use_i && wen_i[p] && (dst_i[p] == id_i);
  end

  assign hit_o  = |match;
  assign pipe_o = match[young_i] ? young_i : ~young_i;
  assign val_o  = val_i[pipe_o];
endmodule

// File: rtl/fwd_operand.sv
// Resolves one source operand: execute beats memory, memory beats register file.
module fwd_operand
  import fwd_pkg::*;
#(
  parameter int REG_W  = 3,
  parameter int DATA_W = 16,
  parameter int PIPES  = 2
) (
  input  logic                          use_i,
  input  logic [REG_W-1:0]              id_i,
  input  logic [DATA_W-1:0]             rf_i,
  input  logic [PIPES-1:0]              ex_wen_i,
  input  logic [PIPES-1:0][REG_W-1:0]   ex_dst_i,
  input  logic [PIPES-1:0][DATA_W-1:0]  ex_val_i,
  input  logic [PIPES-1:0]              ex_load_i,
  input  logic                          ex_young_i,
  input  logic [PIPES-1:0]              mem_wen_i,
  input  logic [PIPES-1:0][REG_W-1:0]   mem_dst_i,
  input  logic [PIPES-1:0][DATA_W-1:0]  mem_val_i,
  input  logic                          mem_young_i,
  output logic [SEL_W-1:0]              sel_o,
  output logic [DATA_W-1:0]             val_o,
  output logic                          stall_o
);
  logic              ex_hit, ex_pipe, mem_hit, mem_pipe;
  logic [DATA_W-1:0] ex_v, mem_v;
  src_sel_e          sel;

  fwd_stage_pick #(.REG_W(REG_W), .DATA_W(DATA_W), .PIPES(PIPES)) u_ex (
    .use_i(use_i), .id_i(id_i), .wen_i(ex_wen_i), .dst_i(ex_dst_i),
    .val_i(ex_val_i), .young_i(ex_young_i),
    .hit_o(ex_hit), .pipe_o(ex_pipe), .val_o(ex_v)
  );

  fwd_stage_pick #(.REG_W(REG_W), .DATA_W(DATA_W), .PIPES(PIPES)) u_mem (
    .use_i(use_i), .id_i(id_i), .wen_i(mem_wen_i), .dst_i(mem_dst_i),
    .val_i(mem_val_i), .young_i(mem_young_i),
    .hit_o(mem_hit), .pipe_o(mem_pipe), .val_o(mem_v)
  );

  always_comb begin
    sel     = SRC_RF;
    val_o   = rf_i;
    stall_o = 1'b0;
    if (ex_hit) begin
      sel     = ex_pipe ? SRC_EX1 : SRC_EX0;
      val_o   = ex_v;
      stall_o = ex_load_i[ex_pipe];
    end else if (mem_hit) begin
      sel     = mem_pipe ? SRC_MEM1 : SRC_MEM0;
      val_o   = mem_v;
    end
  end

  assign sel_o = sel;
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_W   = 3,
  parameter int DATA_W  = 16,
  parameter int PIPES   = 2,
  parameter int OPS_PER = 2,
  localparam int NOPS   = PIPES * OPS_PER
) (
  input  logic [NOPS-1:0]               src_use,
  input  logic [NOPS-1:0][REG_W-1:0]    src_id,
  input  logic [NOPS-1:0][DATA_W-1:0]   rf_val,
  input  logic [PIPES-1:0]              ex_wen,
  input  logic [PIPES-1:0][REG_W-1:0]   ex_dst,
  input  logic [PIPES-1:0][DATA_W-1:0]  ex_val,
  input  logic [PIPES-1:0]              ex_load,
  input  logic                          ex_young,
  input  logic [PIPES-1:0]              mem_wen,
  input  logic [PIPES-1:0][REG_W-1:0]   mem_dst,
  input  logic [PIPES-1:0][DATA_W-1:0]  mem_val,
  input  logic                          mem_young,
  output logic [NOPS-1:0][SEL_W-1:0]    op_sel,
  output logic [NOPS-1:0][DATA_W-1:0]   op_val,
  output logic [NOPS-1:0]               op_stall,
  output logic                          stall_req
);
  for (genvar k = 0; k < NOPS; k++) begin : g_op
    fwd_operand #(.REG_W(REG_W), .DATA_W(DATA_W), .PIPES(PIPES)) u_op (
      .use_i(src_use[k]), .id_i(src_id[k]), .rf_i(rf_val[k]),
      .ex_wen_i(ex_wen), .ex_dst_i(ex_dst), .ex_val_i(ex_val),
      .ex_load_i(ex_load), .ex_young_i(ex_young),
      .mem_wen_i(mem_wen), .mem_dst_i(mem_dst), .mem_val_i(mem_val),
      .mem_young_i(mem_young),
      .sel_o(op_sel[k]), .val_o(op_val[k]), .stall_o(op_stall[k])
    );
  end

  assign stall_req = |op_stall;
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk
  import fwd_pkg::*;
#(
  parameter int REG_W   = 3,
  parameter int DATA_W  = 16,
  parameter int PIPES   = 2,
  parameter int OPS_PER = 2,
  localparam int NOPS   = PIPES * OPS_PER
) (
  input logic [NOPS-1:0]               src_use,
  input logic [NOPS-1:0][REG_W-1:0]    src_id,
  input logic [NOPS-1:0][DATA_W-1:0]   rf_val,
  input logic [PIPES-1:0]              ex_wen,
  input logic [PIPES-1:0][REG_W-1:0]   ex_dst,
  input logic [PIPES-1:0][DATA_W-1:0]  ex_val,
  input logic [PIPES-1:0]              ex_load,
  input logic                          ex_young,
  input logic [PIPES-1:0]              mem_wen,
  input logic [PIPES-1:0][REG_W-1:0]   mem_dst,
  input logic [PIPES-1:0][DATA_W-1:0]  mem_val,
  input logic                          mem_young,
  input logic [NOPS-1:0][SEL_W-1:0]    op_sel,
  input logic [NOPS-1:0][DATA_W-1:0]   op_val,
  input logic [NOPS-1:0]               op_stall,
  input logic                          stall_req
);
  always_comb begin
    for (int k = 0; k < NOPS; k++) begin
      AST_UNUSED_READS_RF: assert (src_use[k] || (op_sel[k] == SRC_RF && !op_stall[k])); // R1
      if (op_sel[k] == SRC_EX0 || op_sel[k] == SRC_EX1)
        AST_EX_PICK_LEGAL: assert (ex_wen[op_sel[k] == SRC_EX1] && ex_dst[op_sel[k] == SRC_EX1] == src_id[k]); // R2
      if (op_sel[k] == SRC_MEM0 || op_sel[k] == SRC_MEM1)
        AST_MEM_PICK_LEGAL: assert (mem_wen[op_sel[k] == SRC_MEM1] && mem_dst[op_sel[k] == SRC_MEM1] == src_id[k]); // R2
      AST_SEL_IN_RANGE: assert (op_sel[k] <= SRC_MEM1); // R5
      if (op_sel[k] == SRC_RF)
        AST_RF_VALUE: assert (op_val[k] == rf_val[k]); // R5
      if (op_sel[k] == SRC_MEM0 || op_sel[k] == SRC_MEM1)
        AST_MEM_VALUE: assert (op_val[k] == mem_val[op_sel[k] == SRC_MEM1]); // R5
      if (op_stall[k])
        AST_STALL_FROM_EX_LOAD: assert ((op_sel[k] == SRC_EX0 && ex_load[0]) || (op_sel[k] == SRC_EX1 && ex_load[1])); // R6
    end
    if (stall_req)
      AST_STALL_HAS_CAUSE: assert (op_stall != '0); // R9
  end
endmodule

bind fwd_unit fwd_unit_chk #(
  .REG_W(REG_W), .DATA_W(DATA_W), .PIPES(PIPES), .OPS_PER(OPS_PER)
) u_chk (.*);

// File: tb/tb_fwd_unit.sv
`timescale 1ns/1ps
module tb_fwd_unit;
  localparam int NOPS = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [NOPS-1:0]        src_use;
  logic [NOPS-1:0][2:0]   src_id;
  logic [NOPS-1:0][15:0]  rf_val;
  logic [1:0]             ex_wen, ex_load, mem_wen;
  logic [1:0][2:0]        ex_dst, mem_dst;
  logic [1:0][15:0]       ex_val, mem_val;
  logic                   ex_young, mem_young;
  logic [NOPS-1:0][2:0]   op_sel;
  logic [NOPS-1:0][15:0]  op_val;
  logic [NOPS-1:0]        op_stall;
  logic                   stall_req;

  fwd_unit dut (.*);

  int total = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected select and stall, from the priority rules R3/R4/R6/R7.
  function automatic void model(input int k, output int sel, output bit stl);
    int pe[2], pm[2];
    sel = 0; stl = 0;
    pe[0] = ex_young; pe[1] = !ex_young;
    pm[0] = mem_young; pm[1] = !mem_young;
    if (!src_use[k]) return;
    for (int i = 0; i < 2; i++)
      if (sel == 0 && ex_wen[pe[i]] && ex_dst[pe[i]] == src_id[k]) begin
        sel = 1 + pe[i]; stl = ex_load[pe[i]];
      end
    for (int i = 0; i < 2; i++)
      if (sel == 0 && mem_wen[pm[i]] && mem_dst[pm[i]] == src_id[k])
        sel = 3 + pm[i];
  endfunction

  function automatic int exp_val(input int k, input int sel);
    case (sel)
      1: return int'(ex_val[0]);
      2: return int'(ex_val[1]);
      3: return int'(mem_val[0]);
      4: return int'(mem_val[1]);
      default: return int'(rf_val[k]);
    endcase
  endfunction

  task automatic clear();
    src_use = '1; src_id = '0;
    for (int k = 0; k < NOPS; k++) rf_val[k] = 16'hA000 + 16'(k);
    ex_wen = '0; ex_load = '0; mem_wen = '0;
    ex_dst = '0; mem_dst = '0;
    ex_val[0] = 16'h1E00; ex_val[1] = 16'h1E11;
    mem_val[0] = 16'h2B00; mem_val[1] = 16'h2B11;
    ex_young = 1'b0; mem_young = 1'b0;
  endtask

  // Full comparison of all operands against the model.
  task automatic check_all(input string tag);
    int s; bit st; bit any;
    any = 0;
    for (int k = 0; k < NOPS; k++) begin
      model(k, s, st);
      any |= st;
      chk(int'(op_sel[k]) == s, {tag, " sel"}, int'(op_sel[k]), s);
      chk(op_stall[k] == st, {tag, " stall"}, int'(op_stall[k]), int'(st));
      if (!st) chk(int'(op_val[k]) == exp_val(k, s), {tag, " R5 val"}, int'(op_val[k]), exp_val(k, s));
    end
    chk(stall_req == any, {tag, " R9 stall_req"}, int'(stall_req), int'(any));
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    clear();
    @(posedge clk);
    step();
    // idle: nothing in flight, everything from register file
    for (int k = 0; k < NOPS; k++)
      chk(op_sel[k] == 3'd0 && op_val[k] == rf_val[k], "R1 idle", int'(op_sel[k]), 0);
    chk(stall_req == 1'b0, "R1 idle stall", int'(stall_req), 0);

    // R2: matching destinations but write enables low
    @(posedge clk); clear(); ex_dst = {3'd0, 3'd0}; mem_dst = {3'd0, 3'd0}; ex_load = 2'b11;
    step();
    chk(op_sel[0] == 3'd0 && !stall_req, "R2 wen low", int'(op_sel[0]), 0);

    // R4: both execute pipes match, younger pipe 1 then pipe 0
    @(posedge clk); clear(); ex_wen = 2'b11; ex_dst = {3'd2, 3'd2}; src_id[0] = 3'd2; ex_young = 1'b1;
    step();
    chk(op_sel[0] == 3'd2 && op_val[0] == 16'h1E11, "R4 ex young1", int'(op_sel[0]), 2);
    @(posedge clk); ex_young = 1'b0;
    step();
    chk(op_sel[0] == 3'd1 && op_val[0] == 16'h1E00, "R4 ex young0", int'(op_sel[0]), 1);

    // R4: both memory pipes match
    @(posedge clk); clear(); mem_wen = 2'b11; mem_dst = {3'd5, 3'd5}; src_id[1] = 3'd5; mem_young = 1'b1;
    step();
    chk(op_sel[1] == 3'd4 && op_val[1] == 16'h2B11, "R4 mem young1", int'(op_sel[1]), 4);

    // R3: execute pipe 0 and memory pipe 1 both match
    @(posedge clk); clear(); ex_wen = 2'b01; ex_dst[0] = 3'd3; mem_wen = 2'b10; mem_dst[1] = 3'd3;
    src_id[2] = 3'd3; mem_young = 1'b1;
    step();
    chk(op_sel[2] == 3'd1 && op_val[2] == 16'h1E00, "R3 ex over mem", int'(op_sel[2]), 1);

    // R6: younger execute producer is a load -> stall
    @(posedge clk); clear(); ex_wen = 2'b11; ex_dst = {3'd4, 3'd4}; ex_load = 2'b10; ex_young = 1'b1;
    src_id[0] = 3'd4;
    step();
    chk(op_stall[0] == 1'b1 && stall_req, "R6 load-use stall", int'(op_stall[0]), 1);
    // R6: younger is non-load, older is the load -> no stall
    @(posedge clk); ex_load = 2'b01;
    step();
    chk(op_stall[0] == 1'b0 && op_sel[0] == 3'd2, "R6 shadowed load", int'(op_stall[0]), 0);

    // R7: memory-stage match never stalls
    @(posedge clk); clear(); mem_wen = 2'b01; mem_dst[0] = 3'd6; ex_load = 2'b11; src_id[3] = 3'd6;
    step();
    chk(op_sel[3] == 3'd3 && !op_stall[3], "R7 mem no stall", int'(op_sel[3]), 3);

    // R1: unused operand with a matching load in execute
    @(posedge clk); clear(); ex_wen = 2'b01; ex_dst[0] = 3'd0; ex_load = 2'b01; src_use = 4'b1110;
    step();
    chk(op_sel[0] == 3'd0 && !op_stall[0] && op_val[0] == rf_val[0], "R1 unused", int'(op_sel[0]), 0);

    // R8: flag register 7 from a compare in execute pipe 1 to a branch in slot 1
    @(posedge clk); clear(); ex_wen = 2'b10; ex_dst[1] = 3'd7; src_id[3] = 3'd7;
    step();
    chk(op_sel[3] == 3'd2 && op_val[3] == 16'h1E11, "R8 flag fwd", int'(op_sel[3]), 2);

    // R9: stall on operand 3 only
    @(posedge clk); clear(); src_id = {3'd1, 3'd2, 3'd2, 3'd2}; ex_wen = 2'b01; ex_dst[0] = 3'd1; ex_load = 2'b01;
    step();
    chk(op_stall == 4'b1000 && stall_req, "R9 single stall", int'(op_stall), 8);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      @(posedge clk);
      for (int k = 0; k < NOPS; k++) begin
        src_use[k] = ($urandom_range(0, 4) != 0);
        src_id[k]  = 3'($urandom_range(0, 7));
        rf_val[k]  = 16'($urandom);
      end
      for (int p = 0; p < 2; p++) begin
        ex_wen[p] = 1'($urandom); ex_load[p] = ($urandom_range(0, 3) == 0);
        mem_wen[p] = 1'($urandom);
        ex_dst[p] = 3'($urandom_range(0, 7)); mem_dst[p] = 3'($urandom_range(0, 7));
        ex_val[p] = 16'($urandom); mem_val[p] = 16'($urandom);
      end
      ex_young = 1'($urandom); mem_young = 1'($urandom);
      step();
      check_all("R4 random");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule